// File: doc/BRIEF.md
# Three-Channel Command/Reply Mailbox

This block lets a host processor and a coprocessor trade 16-bit words over three independent channels. Each channel has a command register and a reply register. The host writes the command register and the coprocessor reads it. The coprocessor writes the reply register and the host reads it. Every register carries a handshake flag, so each side can tell when the other side has acted. Both kinds of flag appear in one host-readable status word. They read 0 once the other side has acted and 1 while it has not.

The host reaches the block through a word-addressed register port with separate read and write strobes. The coprocessor has its own port, addressed by channel number. Read data on both ports is combinational on the address. The side effects of a read, which are flag updates, happen only on a clock edge while the read strobe is high. Each reply channel can drive an interrupt line, enabled by a bit in a host-writable configuration word. Protocols that span several words are built on top of the block by software.

Top module: `cmd_reply_mailbox`

## Requirements
- R1: A host write to host address 2+2k stores a 16-bit command for channel k (k = 0..2). While the coprocessor presents address k, `cp_rdata` returns that command.
- R2: A coprocessor write with `cp_addr` = k stores a 16-bit reply for channel k. Host address 3+2k returns that reply on `host_rdata`.
- R3: Status bit 10+k reads 0 from the edge at which the coprocessor writes reply k. It returns to 1 at the edge of a strobed host read of address 3+2k.
- R4: Status bit 13+k reads 1 from the edge of a host write to command k. It reads 0 from the edge of a strobed coprocessor read of command k.
- R5: Host address 0 is the configuration word. Its bits 9+k are the interrupt enables for reply channel k and read back as written. All other configuration bits read 0.
- R6: `reply_irq[k]` is 1 exactly while configuration bit 9+k is 1 and status bit 10+k is 0.
- R7: After reset, every command and reply register is 0. Status reads 16'h1C00, which means the reply flags are 1 and the command flags are 0. The configuration word and `reply_irq` are 0.
- R8: If a coprocessor write to reply k and a host read of reply k fall in the same cycle, the write wins and status bit 10+k ends at 0. If a host write to command k and a coprocessor read of command k fall in the same cycle, the write wins and status bit 13+k ends at 1.
- R9: Host address 1 is the read-only status word, and its bits 0..9 read 0. The following writes change no register and no flag:
  - host writes to address 1;
  - host writes to a reply address;
  - host writes to an address at or above 8;
  - coprocessor accesses at `cp_addr` = 3.
  Reads of those unused addresses return 0.
- R10: Presenting an address without a read strobe returns the data and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Host word address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (flag side effects) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational on address |
| cp_addr | input | 2 | Coprocessor channel address |
| cp_wr | input | 1 | Coprocessor reply write strobe |
| cp_rd | input | 1 | Coprocessor command read strobe |
| cp_wdata | input | 16 | Coprocessor reply data |
| cp_rdata | output | 16 | Command for the addressed channel |
| reply_irq | output | 3 | Per-channel reply interrupt |

## Verification
The command and reply paths are driven on every channel with all-zero, all-one, alternating and channel-marked words. A stuck or swapped data bit, or a channel mix-up, therefore shows up as a wrong value on the other port. The interrupt enables are swept over all eight combinations with every reply pending. This separates enable gating from flag polarity. Same-cycle collisions on both flag types, writes to read-only and unmapped addresses, and unstrobed peeks are each followed by a status read. That read shows whether write priority, write protection and strobe gating hold.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // Host address map: configuration, status, then command/reply pairs.
   localparam int MBX_CFG_ADDR = 0;
   localparam int MBX_STS_ADDR = 1;
   localparam int MBX_CH_BASE  = 2;

   function automatic int mbx_cmd_addr(input int ch);
      return MBX_CH_BASE + 2 * ch;
   endfunction

   function automatic int mbx_rep_addr(input int ch);
      return MBX_CH_BASE + 2 * ch + 1;
   endfunction
endpackage

// File: rtl/mbx_channel.sv
module mbx_channel #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cmd_wr,
   input  logic              host_rep_rd,
   input  logic              cp_cmd_rd,
   input  logic              cp_rep_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] cp_wdata,
   output logic [DATA_W-1:0] cmd_q,
   output logic [DATA_W-1:0] rep_q,
   output logic              cmd_pend,
   output logic              rep_idle
);
   // Command side: host write wins over a same-cycle coprocessor read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         cmd_pend <= 1'b0;
      end else if (host_cmd_wr) begin
         cmd_q    <= host_wdata;
         cmd_pend <= 1'b1;
      end else if (cp_cmd_rd) begin
         cmd_pend <= 1'b0;
      end
   end

   // Reply side: coprocessor write wins over a same-cycle host read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_q    <= '0;
         rep_idle <= 1'b1;
      end else if (cp_rep_wr) begin
         rep_q    <= cp_wdata;
         rep_idle <= 1'b0;
      end else if (host_rep_rd) begin
         rep_idle <= 1'b1;
      end
   end

   AST_CMD_WR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      host_cmd_wr |=> (cmd_pend && cmd_q == $past(host_wdata))); // R4
   AST_CMD_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_cmd_rd && !host_cmd_wr) |=> !cmd_pend); // R4
   AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !host_cmd_wr |=> $stable(cmd_q)); // R1
   AST_REP_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cp_rep_wr |=> (!rep_idle && rep_q == $past(cp_wdata))); // R3
   AST_REP_RD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rep_rd && !cp_rep_wr) |=> rep_idle); // R3
   AST_REP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cp_rep_wr |=> $stable(rep_q)); // R2
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
   import mbx_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter int DATA_W  = 16,
   parameter int HOST_AW = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [HOST_AW-1:0]            addr,
   input  logic                          wr,
   input  logic                          rd,
   input  logic [DATA_W-1:0]             cfg_word,
   input  logic [DATA_W-1:0]             sts_word,
   input  logic [NUM_CH-1:0][DATA_W-1:0] cmd_words,
   input  logic [NUM_CH-1:0][DATA_W-1:0] rep_words,
   output logic                          cfg_wr,
   output logic [NUM_CH-1:0]             cmd_wr,
   output logic [NUM_CH-1:0]             rep_rd,
   output logic [DATA_W-1:0]             rdata
);
   logic [NUM_CH-1:0] cmd_hit;
   logic [NUM_CH-1:0] rep_hit;
   logic              cfg_hit;
   logic              sts_hit;

   assign cfg_hit = (addr == HOST_AW'(MBX_CFG_ADDR));
   assign sts_hit = (addr == HOST_AW'(MBX_STS_ADDR));
   assign cfg_wr  = wr & cfg_hit;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
      assign cmd_hit[k] = (addr == HOST_AW'(mbx_cmd_addr(k)));
      assign rep_hit[k] = (addr == HOST_AW'(mbx_rep_addr(k)));
      assign cmd_wr[k]  = wr & cmd_hit[k];
      assign rep_rd[k]  = rd & rep_hit[k];
   end

   always_comb begin
      rdata = '0;
      if (cfg_hit) rdata = cfg_word;
      if (sts_hit) rdata = sts_word;
      for (int k = 0; k < NUM_CH; k++) begin
         if (cmd_hit[k]) rdata = cmd_words[k];
         if (rep_hit[k]) rdata = rep_words[k];
      end
   end

   AST_HOST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_wr, cmd_wr, rep_rd})); // R9
endmodule

// File: rtl/mbx_cp_port.sv
module mbx_cp_port #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 16,
   parameter int CP_AW  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CP_AW-1:0]              addr,
   input  logic                          wr,
   input  logic                          rd,
   input  logic [NUM_CH-1:0][DATA_W-1:0] cmd_words,
   output logic [NUM_CH-1:0]             cmd_rd,
   output logic [NUM_CH-1:0]             rep_wr,
   output logic [DATA_W-1:0]             rdata
);
   logic [NUM_CH-1:0] hit;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
      assign hit[k]    = (addr == CP_AW'(k));
      assign cmd_rd[k] = rd & hit[k];
      assign rep_wr[k] = wr & hit[k];
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_CH; k++)
         if (hit[k]) rdata = cmd_words[k];
   end

   AST_CP_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rep_wr)); // R9
endmodule

// File: rtl/cmd_reply_mailbox.sv
module cmd_reply_mailbox
   import mbx_pkg::*;
#(
   parameter int NUM_CH   = 3,
   parameter int DATA_W   = 16,
   parameter int HOST_AW  = 4,
   parameter int CP_AW    = 2,
   parameter int IE_LSB   = 9,
   parameter int RFLG_LSB = 10,
   parameter int CFLG_LSB = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   input  logic [CP_AW-1:0]   cp_addr,
   input  logic               cp_wr,
   input  logic               cp_rd,
   input  logic [DATA_W-1:0]  cp_wdata,
   output logic [DATA_W-1:0]  cp_rdata,
   output logic [NUM_CH-1:0]  reply_irq
);
   localparam int HOST_WORDS = MBX_CH_BASE + 2 * NUM_CH;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if ((1 << HOST_AW) < HOST_WORDS) begin : g_bad_haw
      $error("HOST_AW too small for the host map");
   end
   if ((1 << CP_AW) < NUM_CH) begin : g_bad_caw
      $error("CP_AW too small for NUM_CH");
   end
   if (IE_LSB + NUM_CH > DATA_W || CFLG_LSB + NUM_CH > DATA_W) begin : g_bad_fld
      $error("flag field exceeds DATA_W");
   end
   if (RFLG_LSB + NUM_CH > CFLG_LSB) begin : g_bad_ovl
      $error("reply and command flag fields overlap");
   end

   logic [NUM_CH-1:0]             ie_q;
   logic [NUM_CH-1:0]             cmd_pend;
   logic [NUM_CH-1:0]             rep_idle;
   logic [NUM_CH-1:0][DATA_W-1:0] cmd_words;
   logic [NUM_CH-1:0][DATA_W-1:0] rep_words;
   logic [NUM_CH-1:0]             h_cmd_wr;
   logic [NUM_CH-1:0]             h_rep_rd;
   logic [NUM_CH-1:0]             c_cmd_rd;
   logic [NUM_CH-1:0]             c_rep_wr;
   logic                          cfg_wr;
   logic [DATA_W-1:0]             cfg_word;
   logic [DATA_W-1:0]             sts_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ie_q <= '0;
      else if (cfg_wr) ie_q <= host_wdata[IE_LSB +: NUM_CH];
   end

   always_comb begin
      cfg_word = '0;
      cfg_word[IE_LSB +: NUM_CH] = ie_q;
      sts_word = '0;
      sts_word[RFLG_LSB +: NUM_CH] = rep_idle;
      sts_word[CFLG_LSB +: NUM_CH] = cmd_pend;
   end

   mbx_host_port #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .HOST_AW(HOST_AW)) u_host (
      .clk(clk), .rst_n(rst_n), .addr(host_addr), .wr(host_wr), .rd(host_rd),
      .cfg_word(cfg_word), .sts_word(sts_word), .cmd_words(cmd_words),
      .rep_words(rep_words), .cfg_wr(cfg_wr), .cmd_wr(h_cmd_wr),
      .rep_rd(h_rep_rd), .rdata(host_rdata)
   );

   mbx_cp_port #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CP_AW(CP_AW)) u_cp (
      .clk(clk), .rst_n(rst_n), .addr(cp_addr), .wr(cp_wr), .rd(cp_rd),
      .cmd_words(cmd_words), .cmd_rd(c_cmd_rd), .rep_wr(c_rep_wr),
      .rdata(cp_rdata)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      mbx_channel #(.DATA_W(DATA_W)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .host_cmd_wr(h_cmd_wr[k]), .host_rep_rd(h_rep_rd[k]),
         .cp_cmd_rd(c_cmd_rd[k]), .cp_rep_wr(c_rep_wr[k]),
         .host_wdata(host_wdata), .cp_wdata(cp_wdata),
         .cmd_q(cmd_words[k]), .rep_q(rep_words[k]),
         .cmd_pend(cmd_pend[k]), .rep_idle(rep_idle[k])
      );

      assign reply_irq[k] = ie_q[k] & ~rep_idle[k];

      AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(reply_irq[k]) |-> $past(cp_wr || host_wr)); // R6
      AST_IRQ_DROP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (h_rep_rd[k] && !c_rep_wr[k]) |=> !reply_irq[k]); // R6
   end
endmodule

// File: tb/cmd_reply_mailbox_test.sv
module cmd_reply_mailbox_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic [1:0]  cp_addr = '0;
   logic        cp_wr = 1'b0;
   logic        cp_rd = 1'b0;
   logic [15:0] cp_wdata = '0;
   logic [15:0] cp_rdata;
   logic [2:0]  reply_irq;

   int total = 0;
   int bad   = 0;

   logic [15:0] m_cmd [3];
   logic [15:0] m_rep [3];
   logic [2:0]  m_rflag;
   logic [2:0]  m_cflag;
   logic [2:0]  m_ie;

   always #4 clk = ~clk;

   cmd_reply_mailbox uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cp_addr(cp_addr), .cp_wr(cp_wr), .cp_rd(cp_rd), .cp_wdata(cp_wdata),
      .cp_rdata(cp_rdata), .reply_irq(reply_irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_sts();
      return {m_cflag, m_rflag, 10'b0};
   endfunction

   function automatic logic [15:0] pat(input int i, input int k);
      logic [15:0] base [4];
      base[0] = 16'h0000; base[1] = 16'hFFFF; base[2] = 16'hA5A5; base[3] = 16'h5A5A;
      return base[i] ^ (16'h0101 << k);
   endfunction

   task automatic peek(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b0; host_wr = 1'b0;
      #1 d = host_rdata;
   endtask

   task automatic h_write(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic h_read(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic c_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      cp_addr = a; cp_wdata = d; cp_wr = 1'b1;
      @(negedge clk);
      cp_wr = 1'b0;
   endtask

   task automatic c_read(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      cp_addr = a; cp_rd = 1'b1;
      #1 d = cp_rdata;
      @(negedge clk);
      cp_rd = 1'b0;
   endtask

   task automatic chk_sts(input string req);
      logic [15:0] d;
      peek(4'd1, d);
      chk(req, d, exp_sts());
      chk({req, " irq"}, {13'b0, reply_irq}, {13'b0, m_ie & ~m_rflag});
   endtask

   initial begin
      #1_600_000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      for (int k = 0; k < 3; k++) begin m_cmd[k] = '0; m_rep[k] = '0; end
      m_rflag = 3'b111; m_cflag = 3'b000; m_ie = 3'b000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state
      peek(4'd1, d); chk("R7 status", d, 16'h1C00);
      peek(4'd0, d); chk("R7 config", d, 16'h0000);
      chk("R7 irq", {13'b0, reply_irq}, 16'h0);
      for (int a = 2; a < 8; a++) begin
         peek(4'(a), d); chk("R7 regs", d, 16'h0000);
      end

      // R1/R4 command path, all channels, several patterns
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < 4; i++) begin
            h_write(4'(2 + 2 * k), pat(i, k));
            m_cmd[k] = pat(i, k); m_cflag[k] = 1'b1;
            chk_sts("R4 cmd flag set");
            peek(4'(2 + 2 * k), d); chk("R1 host readback", d, m_cmd[k]);
            c_read(2'(k), d); chk("R1 cp read", d, m_cmd[k]);
            m_cflag[k] = 1'b0;
            chk_sts("R4 cmd flag clear");
         end
      end

      // R2/R3 reply path
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < 4; i++) begin
            c_write(2'(k), ~pat(i, k));
            m_rep[k] = ~pat(i, k); m_rflag[k] = 1'b0;
            chk_sts("R3 reply flag clear");
            // R10 unstrobed peek leaves flag low
            peek(4'(3 + 2 * k), d); chk("R10 peek data", d, m_rep[k]);
            chk_sts("R10 flag kept");
            h_read(4'(3 + 2 * k), d); chk("R2 host read", d, m_rep[k]);
            m_rflag[k] = 1'b1;
            chk_sts("R3 reply flag set");
         end
      end

      // R5/R6 enable sweep over all combinations
      for (int e = 0; e < 8; e++) begin
         h_write(4'd0, 16'hFFFF & ~16'h0E00 | (16'(e) << 9));
         m_ie = 3'(e);
         peek(4'd0, d); chk("R5 config readback", d, 16'(e) << 9);
         chk_sts("R6 idle no irq");
         for (int k = 0; k < 3; k++) begin
            c_write(2'(k), 16'(e * 3 + k)); m_rep[k] = 16'(e * 3 + k); m_rflag[k] = 1'b0;
            chk_sts("R6 irq pending");
         end
         for (int k = 0; k < 3; k++) begin
            h_read(4'(3 + 2 * k), d); chk("R2 sweep read", d, m_rep[k]);
            m_rflag[k] = 1'b1;
            chk_sts("R6 irq released");
         end
      end

      // R8 collisions
      @(negedge clk);
      cp_addr = 2'd1; cp_wdata = 16'hBEEF; cp_wr = 1'b1;
      host_addr = 4'd5; host_rd = 1'b1;
      @(negedge clk);
      cp_wr = 1'b0; host_rd = 1'b0;
      m_rep[1] = 16'hBEEF; m_rflag[1] = 1'b0;
      chk_sts("R8 reply write wins");
      peek(4'd5, d); chk("R8 reply data", d, 16'hBEEF);
      @(negedge clk);
      host_addr = 4'd6; host_wdata = 16'h1234; host_wr = 1'b1;
      cp_addr = 2'd2; cp_rd = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; cp_rd = 1'b0;
      m_cmd[2] = 16'h1234; m_cflag[2] = 1'b1;
      chk_sts("R8 cmd write wins");
      c_read(2'd2, d); chk("R8 cmd data", d, 16'h1234);
      m_cflag[2] = 1'b0;
      chk_sts("R4 after collision");

      // R9 ignored accesses
      h_write(4'd1, 16'hFFFF);
      chk_sts("R9 status write ignored");
      h_write(4'd5, 16'h0000);
      peek(4'd5, d); chk("R9 reply write ignored", d, 16'hBEEF);
      chk_sts("R9 reply flag kept");
      for (int a = 8; a < 16; a++) begin
         h_write(4'(a), 16'hFFFF);
         peek(4'(a), d); chk("R9 unmapped reads 0", d, 16'h0000);
      end
      peek(4'd0, d); chk("R9 config kept", d, 16'(m_ie) << 9);
      for (int k = 0; k < 3; k++) begin
         peek(4'(2 + 2 * k), d); chk("R9 cmd kept", d, m_cmd[k]);
      end
      c_write(2'd3, 16'h7777);
      chk_sts("R9 cp addr 3 write ignored");
      c_read(2'd3, d); chk("R9 cp addr 3 reads 0", d, 16'h0000);
      for (int k = 0; k < 3; k++) begin
         peek(4'(3 + 2 * k), d); chk("R9 replies kept", d, m_rep[k]);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule